// File: doc/BRIEF.md
# Cylinder/Head/Sector to Linear Block Address Converter

This block turns the address held in a disk taskfile (sector number, cylinder low, cylinder high and device/head registers) into a 28-bit linear block address. Each command is handled according to a mode bit in the device/head register. In linear mode the register fields are joined directly into the address. In geometric mode the block maps cylinder, head and sector to a linear address, using the heads-per-cylinder and sectors-per-track values supplied by the host.

A command is started with a one-cycle `start` pulse. The block captures what it needs in that cycle, so the taskfile inputs are free to change afterwards. Linear-mode commands and rejected commands complete in the next cycle. Geometric-mode commands run two passes through one shared shift-and-add multiplier and complete after a fixed latency. `done` pulses once per accepted command. An address request with sector number zero in geometric mode cannot be mapped, so it is reported through `err_o` and produces no address.

Top module: `chs_lba_conv`

## Requirements
- R1: The mode is taken from device/head bit 6 in the start cycle: 1 selects linear mode, 0 selects geometric mode.
- R2: In linear mode the address is {device/head[3:0], cylinder high, cylinder low, sector number}, with the sector number in bits 7:0. `done_o` is high in the first cycle after the start cycle and `err_o` stays low.
- R3: In geometric mode with a nonzero sector, the address is (C·H + head)·S + sector − 1. Here C = {cylinder high, cylinder low}, head = device/head[3:0], H = `geo_heads_i` and S = `geo_spt_i`.
- R4: Cylinder 0, head 0, sector 1 maps to address 0 for every geometry.
- R5: A geometric-mode command whose sector number is 0 raises `err_o` together with `done_o` in the first cycle after the start cycle, and `lba_o` reads 0 in that cycle. `err_o` is never high without `done_o`.
- R6: A geometric-mode command with a nonzero sector raises `done_o` in cycle 2·REG_W+3 after the start cycle (cycle 19 with default parameters).
- R7: `busy_o` is high from the first cycle after a geometric start up to the cycle before `done_o`. `done_o` is never high while `busy_o` is high.
- R8: A `start` pulse seen while `busy_o` is high is ignored. Input changes after the start cycle do not affect the result, and only one `done_o` pulse is produced.
- R9: After reset, `done_o`, `err_o` and `busy_o` are low and `lba_o` is 0.
- R10: `lba_o` changes only in a cycle where `done_o` is high and holds its value between completions.
- R11: Device/head bits 7, 5 and 4 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle command request |
| tf_sector_i | input | REG_W | Sector number register |
| tf_cyl_lo_i | input | REG_W | Cylinder low register |
| tf_cyl_hi_i | input | REG_W | Cylinder high register |
| tf_dev_head_i | input | REG_W | Device/head register (bit 6 mode, bits 3:0 head or top address bits) |
| geo_heads_i | input | HEAD_W+1 | Heads per cylinder |
| geo_spt_i | input | REG_W | Sectors per track |
| busy_o | output | 1 | Geometric computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero-sector error, valid with done_o |
| lba_o | output | 3·REG_W+HEAD_W | Linear block address |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume a geometry in which head < H ≤ 16 and 1 ≤ S ≤ 255, so that the product never wraps past 28 bits. The random stimulus draws H from 1 to 16 and S from 1 to 255, lets the head field take any 4-bit value, and sets the sector to zero in about one command in eight. Directed cases cover the largest cylinder and geometry, the origin mapping, zero sectors in both modes, a second start during computation, and toggling of the ignored device/head bits.

// File: rtl/chs_lba_pkg.sv
// Shared definitions for the taskfile address converter.
// Assumes 8-bit taskfile registers; the mode bit position is fixed by the register layout.
package chs_lba_pkg;

    // Position of the linear/geometric mode select in the device/head register
    localparam int MODE_BIT = 6;

    // Controller sequencing states
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CYL_PASS = 2'd1,
        ST_TRK_PASS = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/chs_lba_fields.sv
// Taskfile field decoder.
// Splits the four taskfile registers into mode, direct linear address,
// cylinder, head and sector, and flags a zero sector number.
// Assumes the head field occupies the low HEAD_W bits of device/head.
module chs_lba_fields #(
    parameter int REG_W  = 8,
    parameter int HEAD_W = 4,
    localparam int LBA_W = 3 * REG_W + HEAD_W,
    localparam int CYL_W = 2 * REG_W
) (
    input  logic [REG_W-1:0]  sector_reg,
    input  logic [REG_W-1:0]  cyl_lo_reg,
    input  logic [REG_W-1:0]  cyl_hi_reg,
    input  logic [REG_W-1:0]  dev_head_reg,
    output logic              lba_mode,
    output logic [LBA_W-1:0]  lba_direct,
    output logic [CYL_W-1:0]  cylinder,
    output logic [HEAD_W-1:0] head,
    output logic [REG_W-1:0]  sector,
    output logic              sector_zero
);
    import chs_lba_pkg::*;

    // Bits of device/head that play no part in addressing
    logic dh_unused_bits;

    // Field extraction from the taskfile registers
    always_comb begin
        lba_mode    = dev_head_reg[MODE_BIT];
        head        = dev_head_reg[HEAD_W-1:0];
        cylinder    = {cyl_hi_reg, cyl_lo_reg};
        sector      = sector_reg;
        lba_direct  = {head, cyl_hi_reg, cyl_lo_reg, sector_reg};
        sector_zero = (sector_reg == '0);
    end

    // Remaining device/head bits, collected so they are visibly left out
    assign dh_unused_bits = ^{dev_head_reg[REG_W-1:MODE_BIT+1],
                              dev_head_reg[MODE_BIT-1:HEAD_W]};

endmodule

// File: rtl/chs_lba_mul.sv
// Radix-2 shift-and-add multiplier.
// A load captures both operands; then one multiplier bit is consumed per
// cycle for B_W cycles, after which fin pulses for one cycle with prod valid.
// Assumes the true product fits in P_W bits (the result wraps otherwise).
module chs_lba_mul #(
    parameter int P_W = 28,
    parameter int B_W = 8,
    localparam int CNT_W = $clog2(B_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [P_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic [P_W-1:0] prod,
    output logic           fin,
    output logic           active
);

    logic [P_W-1:0]   acc_q;
    logic [P_W-1:0]   mcand_q;
    logic [B_W-1:0]   mplier_q;
    logic [CNT_W-1:0] cnt_q;

    // One shift-add step per cycle while active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            cnt_q    <= '0;
            active   <= 1'b0;
            fin      <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                acc_q    <= '0;
                mcand_q  <= a_in;
                mplier_q <= b_in;
                cnt_q    <= CNT_W'(B_W);
                active   <= 1'b1;
            end else if (active) begin
                if (mplier_q[0]) begin
                    acc_q <= acc_q + mcand_q;
                end
                mcand_q  <= mcand_q << 1;
                mplier_q <= mplier_q >> 1;
                cnt_q    <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end
            end
        end
    end

    assign prod = acc_q;

    AST_MUL_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);                                                           // R6
    AST_MUL_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q != '0));                                               // R6
    AST_MUL_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !active);                                                       // R8

endmodule

// File: rtl/chs_lba_ctrl.sv
// Command sequencer for the address converter.
// Accepts start only when idle. Linear and zero-sector commands finish in one
// cycle. Geometric commands run cylinder*heads then (that+head)*spt on the
// shared multiplier, then add sector-1.
// Assumes start is a one-cycle pulse and HPC_W <= REG_W.
module chs_lba_ctrl #(
    parameter int REG_W  = 8,
    parameter int HEAD_W = 4,
    localparam int HPC_W = HEAD_W + 1,
    localparam int LBA_W = 3 * REG_W + HEAD_W,
    localparam int CYL_W = 2 * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              lba_mode,
    input  logic [LBA_W-1:0]  lba_direct,
    input  logic [CYL_W-1:0]  cylinder,
    input  logic [HEAD_W-1:0] head,
    input  logic [REG_W-1:0]  sector,
    input  logic              sector_zero,
    input  logic [HPC_W-1:0]  geo_heads,
    input  logic [REG_W-1:0]  geo_spt,
    input  logic [LBA_W-1:0]  mul_prod,
    input  logic              mul_fin,
    input  logic              mul_active,
    output logic              mul_load,
    output logic [LBA_W-1:0]  mul_a,
    output logic [REG_W-1:0]  mul_b,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [LBA_W-1:0]  lba
);
    import chs_lba_pkg::*;

    ctrl_state_e       state_q;
    logic [HEAD_W-1:0] head_q;
    logic [REG_W-1:0]  sec_q;
    logic [REG_W-1:0]  spt_q;
    logic              idle_start;

    assign idle_start = (state_q == ST_IDLE) && start;
    assign busy       = (state_q != ST_IDLE);

    // Multiplier operand selection: first pass in idle, second after the first finishes
    always_comb begin
        mul_load = (idle_start && !lba_mode && !sector_zero)
                || ((state_q == ST_CYL_PASS) && mul_fin);
        if (state_q == ST_IDLE) begin
            mul_a = LBA_W'(cylinder);
            mul_b = REG_W'(geo_heads);
        end else begin
            mul_a = mul_prod + LBA_W'(head_q);
            mul_b = spt_q;
        end
    end

    // Command sequencing and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            head_q  <= '0;
            sec_q   <= '0;
            spt_q   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            lba     <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (lba_mode) begin
                            lba  <= lba_direct;
                            done <= 1'b1;
                        end else if (sector_zero) begin
                            lba  <= '0;
                            done <= 1'b1;
                            err  <= 1'b1;
                        end else begin
                            head_q  <= head;
                            sec_q   <= sector;
                            spt_q   <= geo_spt;
                            state_q <= ST_CYL_PASS;
                        end
                    end
                end
                ST_CYL_PASS: begin
                    if (mul_fin) begin
                        state_q <= ST_TRK_PASS;
                    end
                end
                ST_TRK_PASS: begin
                    if (mul_fin) begin
                        lba     <= mul_prod + LBA_W'(sec_q) - LBA_W'(1);
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_LINEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_start && lba_mode) |=> (done && !err && (lba == $past(lba_direct)))); // R2
    AST_ZERO_SECTOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_start && !lba_mode && sector_zero) |=> (done && err && (lba == '0))); // R5
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);                                                           // R5
    AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);                                                         // R7
    AST_LBA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lba) |-> done);                                                 // R10
    AST_GEO_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_start && !lba_mode && !sector_zero) |=> (busy && mul_active));     // R7

endmodule

// File: rtl/chs_lba_conv.sv
// Top level of the taskfile address converter.
// Decodes the taskfile registers, sequences the command and shares one
// multiplier between the two geometric passes.
// Assumes the geometry keeps (C*H+head)*S+sector-1 within LBA_W bits.
module chs_lba_conv #(
    parameter int REG_W  = 8,
    parameter int HEAD_W = 4,
    localparam int HPC_W = HEAD_W + 1,
    localparam int LBA_W = 3 * REG_W + HEAD_W,
    localparam int CYL_W = 2 * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] tf_sector_i,
    input  logic [REG_W-1:0] tf_cyl_lo_i,
    input  logic [REG_W-1:0] tf_cyl_hi_i,
    input  logic [REG_W-1:0] tf_dev_head_i,
    input  logic [HPC_W-1:0] geo_heads_i,
    input  logic [REG_W-1:0] geo_spt_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [LBA_W-1:0] lba_o
);

    logic              lba_mode;
    logic [LBA_W-1:0]  lba_direct;
    logic [CYL_W-1:0]  cylinder;
    logic [HEAD_W-1:0] head;
    logic [REG_W-1:0]  sector;
    logic              sector_zero;
    logic              mul_load;
    logic [LBA_W-1:0]  mul_a;
    logic [REG_W-1:0]  mul_b;
    logic [LBA_W-1:0]  mul_prod;
    logic              mul_fin;
    logic              mul_active;

    chs_lba_fields #(.REG_W(REG_W), .HEAD_W(HEAD_W)) u_fields (
        .sector_reg   (tf_sector_i),
        .cyl_lo_reg   (tf_cyl_lo_i),
        .cyl_hi_reg   (tf_cyl_hi_i),
        .dev_head_reg (tf_dev_head_i),
        .lba_mode     (lba_mode),
        .lba_direct   (lba_direct),
        .cylinder     (cylinder),
        .head         (head),
        .sector       (sector),
        .sector_zero  (sector_zero)
    );

    chs_lba_ctrl #(.REG_W(REG_W), .HEAD_W(HEAD_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .lba_mode    (lba_mode),
        .lba_direct  (lba_direct),
        .cylinder    (cylinder),
        .head        (head),
        .sector      (sector),
        .sector_zero (sector_zero),
        .geo_heads   (geo_heads_i),
        .geo_spt     (geo_spt_i),
        .mul_prod    (mul_prod),
        .mul_fin     (mul_fin),
        .mul_active  (mul_active),
        .mul_load    (mul_load),
        .mul_a       (mul_a),
        .mul_b       (mul_b),
        .busy        (busy_o),
        .done        (done_o),
        .err         (err_o),
        .lba         (lba_o)
    );

    chs_lba_mul #(.P_W(LBA_W), .B_W(REG_W)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mul_load),
        .a_in   (mul_a),
        .b_in   (mul_b),
        .prod   (mul_prod),
        .fin    (mul_fin),
        .active (mul_active)
    );

endmodule

// File: tb/tb_chs_lba_conv.sv
module tb_chs_lba_conv;

    localparam int GEO_LAT  = 2 * 8 + 3;
    localparam int WAIT_MAX = 100;
    localparam int WD_MAX   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  tf_sector = '0;
    logic [7:0]  tf_cyl_lo = '0;
    logic [7:0]  tf_cyl_hi = '0;
    logic [7:0]  tf_dev_head = '0;
    logic [4:0]  geo_heads = 5'd1;
    logic [7:0]  geo_spt = 8'd1;
    logic        busy;
    logic        done;
    logic        err;
    logic [27:0] lba;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    chs_lba_conv dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .tf_sector_i   (tf_sector),
        .tf_cyl_lo_i   (tf_cyl_lo),
        .tf_cyl_hi_i   (tf_cyl_hi),
        .tf_dev_head_i (tf_dev_head),
        .geo_heads_i   (geo_heads),
        .geo_spt_i     (geo_spt),
        .busy_o        (busy),
        .done_o        (done),
        .err_o         (err),
        .lba_o         (lba)
    );

    always #10 clk = ~clk;

    // Watchdog: an expired run counts as one failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_MAX) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual %0d cycles expected < %0d", cyc, WD_MAX);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [27:0] exp_lba(input logic [7:0] sec, input logic [7:0] cl,
                                            input logic [7:0] ch, input logic [7:0] dh,
                                            input logic [4:0] hh, input logic [7:0] ss);
        longint unsigned c, v;
        if (dh[6]) return {dh[3:0], ch, cl, sec};
        if (sec == 8'd0) return 28'd0;
        c = longint'({ch, cl});
        v = (c * longint'(hh) + longint'(dh[3:0])) * longint'(ss) + longint'(sec) - 1;
        return v[27:0];
    endfunction

    function automatic bit exp_err(input logic [7:0] sec, input logic [7:0] dh);
        return !dh[6] && (sec == 8'd0);
    endfunction

    // Drive one command, wait for done, return the cycle count after the start cycle
    task automatic issue(input logic [7:0] sec, input logic [7:0] cl, input logic [7:0] ch,
                         input logic [7:0] dh, input logic [4:0] hh, input logic [7:0] ss,
                         output int n);
        @(negedge clk);
        tf_sector = sec; tf_cyl_lo = cl; tf_cyl_hi = ch; tf_dev_head = dh;
        geo_heads = hh; geo_spt = ss; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < WAIT_MAX) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_cmd(input logic [7:0] sec, input logic [7:0] cl, input logic [7:0] ch,
                           input logic [7:0] dh, input logic [4:0] hh, input logic [7:0] ss,
                           input string req);
        int n, lat;
        logic [27:0] e;
        bit ee;
        e  = exp_lba(sec, cl, ch, dh, hh, ss);
        ee = exp_err(sec, dh);
        lat = (dh[6] || ee) ? 1 : GEO_LAT;
        issue(sec, cl, ch, dh, hh, ss, n);
        check(n == lat, (lat == 1) ? "R1" : "R6", "latency", n, lat);
        check(err == ee, ee ? "R5" : "R1", "err", err, ee);
        check(lba == e, req, "lba", lba, e);
    endtask

    initial begin
        int n;
        logic [27:0] e, held;
        void'($urandom(32'd4711));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(done == 1'b0 && err == 1'b0 && busy == 1'b0, "R9", "flags", {done, err, busy}, 0);
        check(lba == 28'd0, "R9", "lba after reset", lba, 0);

        // R2 linear concatenation
        run_cmd(8'h12, 8'h34, 8'h56, 8'h47, 5'd16, 8'd63, "R2");
        // R11 ignored device/head bits give the same address
        run_cmd(8'h12, 8'h34, 8'h56, 8'hF7, 5'd3, 8'd9, "R11");
        run_cmd(8'hFF, 8'hFF, 8'hFF, 8'h4F, 5'd1, 8'd1, "R2");
        // R1 zero sector in linear mode is a valid address
        run_cmd(8'h00, 8'h00, 8'h00, 8'h40, 5'd16, 8'd63, "R1");
        // R4 origin for several geometries
        run_cmd(8'd1, 8'd0, 8'd0, 8'hA0, 5'd16, 8'd63, "R4");
        run_cmd(8'd1, 8'd0, 8'd0, 8'h00, 5'd1, 8'd1, "R4");
        // R3 typical and extreme geometry
        run_cmd(8'd17, 8'h2C, 8'h01, 8'h05, 5'd15, 8'd63, "R3");
        run_cmd(8'd255, 8'hFF, 8'hFF, 8'h0F, 5'd16, 8'd255, "R3");
        run_cmd(8'd1, 8'd0, 8'd0, 8'h01, 5'd2, 8'd1, "R3");
        // R11 ignored bits in geometric mode
        run_cmd(8'd17, 8'h2C, 8'h01, 8'hB5, 5'd15, 8'd63, "R11");
        // R5 zero sector in geometric mode
        run_cmd(8'd0, 8'h10, 8'h00, 8'h02, 5'd4, 8'd17, "R5");

        // R7 busy during computation, R8 second start ignored and inputs free after start
        e = exp_lba(8'd9, 8'h21, 8'h00, 8'h03, 5'd6, 8'd40);
        @(negedge clk);
        tf_sector = 8'd9; tf_cyl_lo = 8'h21; tf_cyl_hi = 8'h00; tf_dev_head = 8'h03;
        geo_heads = 5'd6; geo_spt = 8'd40; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7", "busy cycle 1", busy, 1);
        tf_sector = 8'd200; tf_cyl_lo = 8'h77; tf_dev_head = 8'h4A;
        geo_heads = 5'd2; geo_spt = 8'd3;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 6;
        while (!done && n < WAIT_MAX) begin
            @(negedge clk);
            n++;
        end
        check(n == GEO_LAT, "R8", "latency with extra start", n, GEO_LAT);
        check(lba == e && !err, "R8", "lba with changed inputs", lba, e);
        held = lba;
        begin
            int extra = 0;
            repeat (30) begin
                @(negedge clk);
                if (done) extra++;
                if (busy) extra++;
            end
            check(extra == 0, "R8", "extra done or busy", extra, 0);
        end
        // R10 address held between completions
        check(lba == held, "R10", "lba hold", lba, held);

        // Random commands
        for (int i = 0; i < 200; i++) begin
            logic [7:0] sec, cl, ch, dh, ss;
            logic [4:0] hh;
            sec = 8'($urandom_range(255));
            if ($urandom_range(7) == 0) sec = 8'd0;
            cl = 8'($urandom_range(255));
            ch = 8'($urandom_range(255));
            dh = 8'($urandom_range(255));
            hh = 5'($urandom_range(16, 1));
            ss = 8'($urandom_range(255, 1));
            run_cmd(sec, cl, ch, dh, hh, ss, dh[6] ? "R2" : "R3");
            held = lba;
            @(negedge clk);
            tf_cyl_lo = ~tf_cyl_lo;
            @(negedge clk);
            check(lba == held, "R10", "random hold", lba, held);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule